// File: doc/BRIEF.md
# Test Access Port with Capture-Only Pin Scan

This block is the serial test port of a memory device. Four board-level signals drive it: a test clock, a mode select, serial data in and an optional active-low asynchronous reset. It returns serial data out together with an output enable. Inside are the usual sixteen-state port controller, an instruction register, a one-bit bypass path, a fixed identification register and a pin scan register. The pin scan register has one cell per sampled device input. Its one scan instruction, SAMPLE, photographs the inputs and shifts them out. It never loads anything back towards the pins, so leaving the data path through its update state does nothing more than a pause would. Any opcode the block does not recognise falls back to the bypass path, which keeps the length of a daisy chain predictable.

The controller moves on each rising test clock according to the mode select (TMS). The states and their TMS=0 / TMS=1 successors are as follows:
- TestReset → Idle / TestReset
- Idle → Idle / SelData
- SelData → CapData / SelInstr
- CapData → ShData / Ex1Data
- ShData → ShData / Ex1Data
- Ex1Data → PauData / UpdData
- PauData → PauData / Ex2Data
- Ex2Data → ShData / UpdData
- UpdData → Idle / SelData
- SelInstr → CapInstr / TestReset
- CapInstr → ShInstr / Ex1Instr
- ShInstr → ShInstr / Ex1Instr
- Ex1Instr → PauInstr / UpdInstr
- PauInstr → PauInstr / Ex2Instr
- Ex2Instr → ShInstr / UpdInstr
- UpdInstr → Idle / SelData

Pin bit 0 is meant for the device clock input. Its captured value is unspecified whenever that clock toggles near the capture edge. The same holds for any other pin that is changing at that edge.

Top module: `tap_top`

## Requirements
- R1: The controller follows the state list above on each rising edge of `tck`, and a low `trst_n` forces TestReset at once, whatever the clock is doing.
- R2: Five consecutive rising edges with `tms` high bring the controller to TestReset from any state.
- R3: Reset or TestReset makes IDCODE (4'b0010) the active instruction. A data scan then returns the 32-bit `ID_VALUE`, LSB first, followed by the bits shifted in.
- R4: CapInstr loads the instruction shift stage with bit 0 = 1, bit 1 = 0 and all higher bits 0. ShInstr shifts it towards `tdo`, LSB first.
- R5: The active instruction changes only in UpdInstr (or TestReset). Opcodes: IDCODE 4'b0010, SAMPLE 4'b0011, BYPASS 4'b1111.
- R6: With SAMPLE active, CapData loads pin scan cell i from `pin_in[i]`. ShData shifts one cell per clock with cell 0 nearest `tdo`, and `tdi` enters cell `N_PINS-1`, so the chain is `N_PINS` long.
- R7: Passing through PauData keeps the partly shifted contents, and shifting resumes where it stopped. UpdData changes no output and no register, exactly like a pause, and the instruction stays SAMPLE.
- R8: With BYPASS active the data path is one cell long and holds 0 after CapData.
- R9: Every opcode other than the three defined ones selects the one-cell bypass path.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly when that edge finds the controller in ShData or ShInstr, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset; tie high if unused |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | N_PINS | Device pin values seen by the pin scan register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while a shift state is driving `tdo` |

## Verification
Each instruction is followed by a data scan several bits longer than its chain. The length of the chain shows up as the position where the bench's own `tdi` bits re-emerge. This separates the 1-bit bypass from the 32-bit identifier and from the 16-cell pin chain. Two different pin patterns, one of them with alternating bits, show that cells are captured in the right order and that a rescan after an update recaptures rather than reusing old contents. Reserved opcodes, a detour through the pause states mid-scan, a five-high mode-select escape and an asynchronous reset in the middle of a shift each exercise one distinct controller path.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [3:0] {
        S_TLR,  S_RTI,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_PINS
    } dr_sel_e;

    typedef struct packed {
        logic tlr;
        logic cap_dr;
        logic sh_dr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
    } tap_ctl_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o,
    output tap_ctl_t   ctl_o
);

    tap_state_e state_q;
    tap_state_e state_d;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= S_TLR;
        else         state_q <= state_d;
    end

    // next-state function
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_TLR:    state_d = tms ? S_TLR    : S_RTI;
            S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
            S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: state_d = tms ? S_SEL_DR : S_RTI;
            S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
            S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: state_d = tms ? S_SEL_DR : S_RTI;
            default:  state_d = S_TLR;
        endcase
    end

    // per-state strobes; the data-side update state drives nothing
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            S_TLR:    ctl_o.tlr    = 1'b1;
            S_CAP_DR: ctl_o.cap_dr = 1'b1;
            S_SH_DR:  ctl_o.sh_dr  = 1'b1;
            S_CAP_IR: ctl_o.cap_ir = 1'b1;
            S_SH_IR:  ctl_o.sh_ir  = 1'b1;
            S_UPD_IR: ctl_o.upd_ir = 1'b1;
            default:  ctl_o = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir #(
    parameter int              IR_W     = 4,
    parameter logic [IR_W-1:0] RESET_OP = 4'b0010
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tlr,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_o,
    output logic            so_o
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] shreg_q;
    logic [IR_W-1:0] active_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  shreg_q <= CAP_PAT;
        else if (cap) shreg_q <= CAP_PAT;
        else if (sh)  shreg_q <= {tdi, shreg_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  active_q <= RESET_OP;
        else if (tlr) active_q <= RESET_OP;
        else if (upd) active_q <= shreg_q;
    end

    assign ir_o = active_q;
    assign so_o = shreg_q[0];

endmodule

// File: rtl/tap_bsr_cell.sv
`timescale 1ns/1ps
module tap_bsr_cell (
    input  logic tck,
    input  logic trst_n,
    input  logic cap,
    input  logic sh,
    input  logic pin,
    input  logic shift_in,
    output logic q_o
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  q_o <= 1'b0;
        else if (cap) q_o <= pin;
        else if (sh)  q_o <= shift_in;
    end

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int              N_PINS   = 16,
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_E0F3
) (
    input  logic              tck,
    input  logic              trst_n,
    input  dr_sel_e           sel,
    input  logic              cap,
    input  logic              sh,
    input  logic              tdi,
    input  logic [N_PINS-1:0] pins,
    output logic              so_o,
    output logic [N_PINS-1:0] bsr_o,
    output logic              byp_o
);

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            pin_cap;
    logic            pin_sh;
    logic [N_PINS-1:0] chain_in;

    // bypass cell: cleared on every capture, shifts only when selected
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      byp_q <= 1'b0;
        else if (cap)                     byp_q <= 1'b0;
        else if (sh && sel == DR_BYPASS)  byp_q <= tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                     id_q <= ID_VALUE;
        else if (cap && sel == DR_IDENT) id_q <= ID_VALUE;
        else if (sh  && sel == DR_IDENT) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    assign pin_cap  = cap && (sel == DR_PINS);
    assign pin_sh   = sh  && (sel == DR_PINS);
    assign chain_in = {tdi, bsr_o[N_PINS-1:1]};

    for (genvar i = 0; i < N_PINS; i++) begin : g_cell
        tap_bsr_cell u_cell (
            .tck      (tck),
            .trst_n   (trst_n),
            .cap      (pin_cap),
            .sh       (pin_sh),
            .pin      (pins[i]),
            .shift_in (chain_in[i]),
            .q_o      (bsr_o[i])
        );
    end

    always_comb begin
        unique case (sel)
            DR_IDENT: so_o = id_q[0];
            DR_PINS:  so_o = bsr_o[0];
            default:  so_o = byp_q;
        endcase
    end

    assign byp_o = byp_q;

endmodule

// File: rtl/tap_top.sv
`timescale 1ns/1ps
module tap_top
    import tap_pkg::*;
#(
    parameter int              N_PINS    = 16,
    parameter int              IR_W      = 4,
    parameter int              ID_W      = 32,
    parameter logic [ID_W-1:0] ID_VALUE  = 32'h1A5C_E0F3,
    parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010,
    parameter logic [IR_W-1:0] OP_SAMPLE = 4'b0011,
    parameter logic [IR_W-1:0] OP_BYPASS = 4'b1111
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [N_PINS-1:0] pin_in,
    output logic              tdo,
    output logic              tdo_oe
);

    tap_state_e        state_q;
    tap_ctl_t          ctl;
    logic [IR_W-1:0]   ir_active;
    logic              ir_so;
    dr_sel_e           dr_sel;
    logic              dr_so;
    logic [N_PINS-1:0] bsr_q;
    logic              byp_q;
    logic              tdo_q;
    logic              oe_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state_q),
        .ctl_o   (ctl)
    );

    tap_ir #(
        .IR_W     (IR_W),
        .RESET_OP (OP_IDCODE)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tlr    (ctl.tlr),
        .cap    (ctl.cap_ir),
        .sh     (ctl.sh_ir),
        .upd    (ctl.upd_ir),
        .tdi    (tdi),
        .ir_o   (ir_active),
        .so_o   (ir_so)
    );

    // decode: anything unrecognised falls back to bypass
    always_comb begin
        if (ir_active == OP_SAMPLE)      dr_sel = DR_PINS;
        else if (ir_active == OP_IDCODE) dr_sel = DR_IDENT;
        else                             dr_sel = DR_BYPASS;
    end

    tap_dr #(
        .N_PINS   (N_PINS),
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .sel    (dr_sel),
        .cap    (ctl.cap_dr),
        .sh     (ctl.sh_dr),
        .tdi    (tdi),
        .pins   (pin_in),
        .so_o   (dr_so),
        .bsr_o  (bsr_q),
        .byp_o  (byp_q)
    );

    // output retimed on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            oe_q  <= 1'b0;
            tdo_q <= 1'b0;
        end else begin
            oe_q  <= ctl.sh_dr | ctl.sh_ir;
            tdo_q <= ctl.sh_ir ? ir_so : (ctl.sh_dr ? dr_so : 1'b0);
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/tap_top_sva.sv
`timescale 1ns/1ps
module tap_top_sva
    import tap_pkg::*;
#(
    parameter int N_PINS = 16,
    parameter int IR_W   = 4
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              tdo,
    input logic              tdo_oe,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir_active,
    input logic [N_PINS-1:0] bsr_q,
    input logic              byp_q
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ones_q <= 3'd0;
        else if (!tms)            ones_q <= 3'd0;
        else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
    end

    a_r1_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_TLR && tms) |=> (state == S_TLR));

    a_r1_capture_to_shift: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_CAP_DR && !tms) |=> (state == S_SH_DR));

    a_r2_five_high: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state == S_TLR));

    a_r5_ir_stable: assert property (@(posedge tck) disable iff (!trst_n)
        (state != S_UPD_IR && state != S_TLR) |=> $stable(ir_active));

    a_r7_update_inert: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_UPD_DR) |=> $stable(bsr_q));

    a_r7_pause_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_PAU_DR) |=> $stable(bsr_q));

    a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_CAP_DR) |=> !byp_q);

    a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == S_SH_DR || state == S_SH_IR));

    a_r10_quiet_low: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

endmodule

bind tap_top tap_top_sva #(
    .N_PINS (N_PINS),
    .IR_W   (IR_W)
) u_sva (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe),
    .state     (state_q),
    .ir_active (ir_active),
    .bsr_q     (bsr_q),
    .byp_q     (byp_q)
);

// File: tb/tb_tap_top.sv
`timescale 1ns/1ps
module tb_tap_top;

    localparam int          N_PINS = 16;
    localparam int          IR_W   = 4;
    localparam logic [31:0] ID_VAL = 32'h1A5C_E0F3;
    localparam logic [3:0]  OP_ID  = 4'b0010;
    localparam logic [3:0]  OP_SMP = 4'b0011;
    localparam logic [3:0]  OP_BYP = 4'b1111;

    logic              tck    = 1'b0;
    logic              trst_n = 1'b0;
    logic              tms    = 1'b1;
    logic              tdi    = 1'b0;
    logic [N_PINS-1:0] pins   = '0;
    logic              tdo;
    logic              tdo_oe;

    always #10 tck = ~tck;

    tap_top dut (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .tdi    (tdi),
        .pin_in (pins),
        .tdo    (tdo),
        .tdo_oe (tdo_oe)
    );

    typedef struct {
        logic  exp;
        bit    care;
        string req;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: every shifting rising edge consumes one expected item
    initial begin
        forever begin
            item_t it;
            @(posedge tck);
            if (tdo_oe === 1'b1) begin
                if (q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R10: unexpected shift, got oe=%b expected oe=0", tdo_oe);
                end else begin
                    it = q.pop_front();
                    if (it.care) check(it.req, tdo, it.exp);
                end
            end
        end
    end

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    // driver for a shifting clock: pushes the expected tdo bit
    task automatic sh(input logic m, input logic d, input logic e, input bit c, input string req);
        item_t it;
        @(negedge tck);
        #1;
        it.exp = e; it.care = c; it.req = req;
        q.push_back(it);
        tms = m;
        tdi = d;
    endtask

    task automatic scan_ir(input logic [3:0] op, input bit detour);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < IR_W; i++) begin
            bit brk = (i == IR_W - 1) || (detour && i == 1);
            sh(brk, op[i], (i == 0) ? 1'b1 : 1'b0, 1'b1, "R4");
            if (detour && i == 1) begin
                step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end
        end
        step(1, 0);
        step(0, 0);
    endtask

    // data scan: the first len bits are the captured value, then din re-emerges
    task automatic scan_dr(input int n, input int len, input logic [63:0] cap,
                           input logic [63:0] din, input logic [63:0] care,
                           input string req, input int pause_at);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            bit brk = (i == n - 1) || (i == pause_at - 1);
            logic e = (i < len) ? cap[i] : din[i - len];
            bit   c = (i >= len) || care[i];
            sh(brk, din[i], e, c, req);
            if (i == pause_at - 1) begin
                step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end
        end
        step(1, 0);
        step(0, 0);
        // outputs now reflect the data update state
        check("R7", tdo_oe, 1'b0);
        check("R7", tdo, 1'b0);
    endtask

    localparam logic [63:0] DIN_A = 64'hC3A5_96F0_0F69_5A3C;
    localparam logic [63:0] DIN_B = 64'h5E17_A2C4_9B3D_60F8;
    localparam logic [63:0] CARE_NOCLK = ~64'h1;

    initial begin
        repeat (3) @(negedge tck);
        #1;
        check("R10", tdo_oe, 1'b0);
        check("R10", tdo, 1'b0);
        trst_n = 1'b1;
        step(0, 0);

        // R3: identifier is the instruction after reset
        scan_dr(36, 32, {32'h0, ID_VAL}, DIN_A, '1, "R3", -1);

        // R8: bypass, one cell, captures 0 (IR capture checked as R4)
        scan_ir(OP_BYP, 0);
        scan_dr(6, 1, 64'h0, DIN_B, '1, "R8", -1);

        // R6: pin sample, bit 0 is the clock pin and not compared
        pins = 16'hA53C;
        scan_ir(OP_SMP, 1);    // R1: path through the instruction pause states
        scan_dr(20, 16, {48'h0, 16'hA53C}, DIN_A, CARE_NOCLK, "R6", -1);

        // R7: pause mid-scan, resume, then rescan after update recaptures
        pins = 16'h5AC3;
        scan_dr(20, 16, {48'h0, 16'h5AC3}, DIN_B, CARE_NOCLK, "R7", 8);
        pins = 16'h0FF1;
        scan_dr(18, 16, {48'h0, 16'h0FF1}, DIN_A, CARE_NOCLK, "R7", -1);

        // R9: reserved and undefined opcodes act as bypass
        scan_ir(4'b0101, 0);
        scan_dr(5, 1, 64'h0, DIN_A, '1, "R9", -1);
        scan_ir(4'b0000, 0);
        scan_dr(5, 1, 64'h0, DIN_B, '1, "R9", -1);

        // R2: five high mode-select edges from inside a data shift
        scan_ir(OP_SMP, 0);
        step(1, 0); step(0, 0); step(0, 0);
        sh(0, 0, 1'b0, 1'b0, "R2");
        sh(1, 0, 1'b0, 1'b0, "R2");
        step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        step(1, 0);
        check("R2", tdo_oe, 1'b0);
        step(0, 0);
        scan_dr(34, 32, {32'h0, ID_VAL}, DIN_B, '1, "R2", -1);

        // R1: asynchronous reset in the middle of a bypass shift
        scan_ir(OP_BYP, 0);
        step(1, 0); step(0, 0); step(0, 0);
        sh(0, 1, 1'b0, 1'b0, "R1");
        sh(0, 1, 1'b0, 1'b0, "R1");
        @(negedge tck);
        #1;
        trst_n = 1'b0;
        tms    = 1'b0;
        #3;
        check("R1", tdo_oe, 1'b0);
        check("R1", tdo, 1'b0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        step(0, 0);
        scan_dr(33, 32, {32'h0, ID_VAL}, DIN_A, '1, "R1", -1);

        step(0, 0);
        step(0, 0);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d expected bits never shifted, expected 0", q.size());
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule